// File: doc/BRIEF.md
# Paged Memory-Space Address Decoder

This block sits between a DSP core and its memories. It turns one access request (an address space, a 16-bit address and the current processor-mode word) into exactly one target select. The possible targets are the memory-mapped register file, the scratch-pad RAM, the on-chip dual-access RAM, the on-chip ROM, external program memory, external data memory and the external I/O ports. A reserved location raises an error flag and selects nothing.

Program space is paged. A 4-bit page register, which software writes, is joined to the 16-bit address to form a 20-bit external program address across 16 pages of 64K words. Three bits of the mode word steer the map. The overlay bit folds the low 16K of every program page onto on-chip RAM. The microcomputer bit exposes the ROM at the top of page 0. The data-ROM bit makes the ROM visible in data space.

The decode path is purely combinational. The page register is the only state.

Top module: `mem_space_decoder`

## Requirements
- R1: In data space (acc_space = 2'b01), addresses 0000h–005Fh select the register file (tgt_sel bit 0), and 0060h–007Fh select scratch-pad RAM (tgt_sel bit 1).
- R2: In data space, addresses 0080h–3FFFh select dual-access RAM (tgt_sel bit 2), whatever the overlay bit is.
- R3: In program space (acc_space = 2'b00) with the overlay bit (pmode bit 5) at 1, addresses 0080h–3FFFh select dual-access RAM on every page. Addresses 0000h–007Fh set acc_err and select nothing.
- R4: In program space with the overlay bit at 0, addresses 0000h–3FFFh select external program memory (tgt_sel bit 4) on every page.
- R5: In program space, addresses F000h–FFFFh select ROM (tgt_sel bit 3) only when the page is 0 and the microcomputer bit (pmode bit 6) is 0. Every other address from 4000h to FFFFh selects external program memory.
- R6: In data space, addresses F000h–FEFFh select ROM when the data-ROM bit (pmode bit 3) is 1. All other data addresses from 4000h to FFFFh select external data memory (tgt_sel bit 5).
- R7: Any I/O-space access (acc_space = 2'b10) selects external I/O (tgt_sel bit 6) and asserts xio_stb.
- R8: ext_addr is {page, acc_addr} for external program, and {4'h0, acc_addr} for external data or I/O. It is 0 when no external target is selected.
- R9: The page register resets to 0. A write loads it at the next clock edge, so an access in the same cycle as the write still uses the old page.
- R10: A valid access with no error selects exactly one target. With acc_valid low, nothing is selected and acc_err is 0. Space code 2'b11 sets acc_err.
- R11: The pmode bits other than bits 6, 5 and 3 have no effect on any output.
- R12: xprog_stb, xdata_stb and xio_stb each equal tgt_sel bits 4, 5 and 6 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pg_we | input | 1 | Page register write enable |
| pg_wdata | input | 4 | Page register write value |
| pmode | input | 16 | Processor-mode word |
| acc_valid | input | 1 | Access request present |
| acc_space | input | 2 | 00 program, 01 data, 10 I/O, 11 invalid |
| acc_addr | input | 16 | Access address |
| tgt_sel | output | 7 | One-hot target select |
| acc_err | output | 1 | Reserved or invalid access |
| ext_addr | output | 20 | External address |
| xprog_stb | output | 1 | External program strobe |
| xdata_stb | output | 1 | External data strobe |
| xio_stb | output | 1 | External I/O strobe |

## Verification
The page-register write and a program-space decode can happen in the same cycle. The test provokes this by raising pg_we with a new page while a program access to the external region is held steady. It is judged at ext_addr: the upper four bits must still show the old page before the edge and the new page after it. Around this case, the test sweeps every space and mode combination across all region boundaries on pages 0, 1 and 15. It also loads the unused mode bits with junk to confirm they are ignored.

// File: rtl/msd_pkg.sv
// Package: shared encodings for the paged address decoder.
// Assumes: a single core request per cycle, a 16-bit address and a 4-bit page.
package msd_pkg;
    typedef enum logic [1:0] {
        SP_PROG = 2'b00,
        SP_DATA = 2'b01,
        SP_IO   = 2'b10,
        SP_BAD  = 2'b11
    } space_e;

    typedef enum logic [2:0] {
        T_MMR   = 3'd0,
        T_SPAD  = 3'd1,
        T_DARAM = 3'd2,
        T_ROM   = 3'd3,
        T_XPROG = 3'd4,
        T_XDATA = 3'd5,
        T_XIO   = 3'd6
    } target_e;

    localparam int NUM_TGT = 7;

    // Bit positions in the processor-mode word that the decoder reads.
    localparam int MODE_MPMC_BIT = 6;
    localparam int MODE_OVLY_BIT = 5;
    localparam int MODE_DROM_BIT = 3;

    typedef struct packed {
        logic mpmc;
        logic ovly;
        logic drom;
    } mode_t;

    typedef struct packed {
        logic    hit;
        logic    err;
        target_e tgt;
    } decode_t;
endpackage

// File: rtl/msd_page_reg.sv
// Module: program page register.
// Holds the upper bits of the program address. It loads on a write enable
// and resets to page 0.
// Assumes: synchronous active-low reset; a write is seen by accesses one
// cycle later.
module msd_page_reg #(
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PAGE_W-1:0] wdata,
    output logic [PAGE_W-1:0] page
);
    // Load the page on write; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   page <= '0;
        else if (we)  page <= wdata;
    end

    // R9
    page_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> page == $past(wdata));
    // R9
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(page));
endmodule

// File: rtl/msd_region.sv
// Module: region classifier.
// Maps a space, an address, the page and the mode bits to one target,
// or to an error.
// Assumes: the ROM sits at the top of the address range and the boundaries
// are ordered MMR_LAST < SPAD_LAST < ONCHIP_LAST < ROM_FIRST <= DROM_LAST.
module msd_region
    import msd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 4,
    parameter logic [ADDR_W-1:0] MMR_LAST    = 16'h005F,
    parameter logic [ADDR_W-1:0] SPAD_LAST   = 16'h007F,
    parameter logic [ADDR_W-1:0] ONCHIP_LAST = 16'h3FFF,
    parameter logic [ADDR_W-1:0] ROM_FIRST   = 16'hF000,
    parameter logic [ADDR_W-1:0] DROM_LAST   = 16'hFEFF
) (
    input  logic              valid,
    input  space_e            space,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PAGE_W-1:0] page,
    input  mode_t             mode,
    output decode_t           dec
);
    logic page_zero;
    logic in_low;
    logic in_rom;

    // Address-range flags shared by the program and data decodes.
    always_comb begin
        page_zero = (page == '0);
        in_low    = (addr <= ONCHIP_LAST);
        in_rom    = (addr >= ROM_FIRST);
    end

    // Classify the request into a single target or an error.
    always_comb begin
        dec.hit = 1'b0;
        dec.err = 1'b0;
        dec.tgt = T_MMR;
        if (valid) begin
            case (space)
                SP_DATA: begin
                    dec.hit = 1'b1;
                    if (addr <= MMR_LAST)       dec.tgt = T_MMR;
                    else if (addr <= SPAD_LAST) dec.tgt = T_SPAD;
                    else if (in_low)            dec.tgt = T_DARAM;
                    else if (mode.drom && in_rom && addr <= DROM_LAST)
                                                dec.tgt = T_ROM;
                    else                        dec.tgt = T_XDATA;
                end
                SP_PROG: begin
                    if (in_low && mode.ovly) begin
                        if (addr <= SPAD_LAST) begin
                            dec.err = 1'b1;
                        end else begin
                            dec.hit = 1'b1;
                            dec.tgt = T_DARAM;
                        end
                    end else if (!in_low && in_rom && page_zero && !mode.mpmc) begin
                        dec.hit = 1'b1;
                        dec.tgt = T_ROM;
                    end else begin
                        dec.hit = 1'b1;
                        dec.tgt = T_XPROG;
                    end
                end
                SP_IO: begin
                    dec.hit = 1'b1;
                    dec.tgt = T_XIO;
                end
                default: dec.err = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/msd_select_gen.sv
// Module: select and external-address generator.
// Expands a classified target into one-hot selects, forms the 20-bit
// external address and drives the external strobes.
// Assumes: dec.hit and dec.err are never both set.
module msd_select_gen
    import msd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 4,
    parameter int N_TGT  = NUM_TGT
) (
    input  decode_t                   dec,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [PAGE_W-1:0]         page,
    output logic [N_TGT-1:0]          sel,
    output logic [ADDR_W+PAGE_W-1:0]  ext_addr,
    output logic                      xprog_stb,
    output logic                      xdata_stb,
    output logic                      xio_stb
);
    localparam int EXT_W = ADDR_W + PAGE_W;

    // One decoder line for each target index.
    for (genvar g = 0; g < N_TGT; g++) begin : g_sel
        localparam logic [2:0] IDX = 3'(g);
        assign sel[g] = dec.hit && (dec.tgt == IDX);
    end

    // Form the external address; the page applies to program space only.
    always_comb begin
        ext_addr = '0;
        if (dec.hit) begin
            case (dec.tgt)
                T_XPROG:        ext_addr = {page, addr};
                T_XDATA, T_XIO: ext_addr = EXT_W'(addr);
                default:        ext_addr = '0;
            endcase
        end
    end

    // Drive the external space strobes from their selects.
    always_comb begin
        xprog_stb = sel[T_XPROG];
        xdata_stb = sel[T_XDATA];
        xio_stb   = sel[T_XIO];
    end
endmodule

// File: rtl/mem_space_decoder.sv
// Module: paged memory-space address decoder (top).
// Splits the mode word, holds the program page, classifies each request
// and drives one-hot selects, the error flag, the 20-bit external address
// and the strobes.
// Assumes: the request inputs are stable while they are sampled; the
// decode is combinational and only the page is registered.
module mem_space_decoder
    import msd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 4,
    parameter int MODE_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pg_we,
    input  logic [PAGE_W-1:0]        pg_wdata,
    input  logic [MODE_W-1:0]        pmode,
    input  logic                     acc_valid,
    input  logic [1:0]               acc_space,
    input  logic [ADDR_W-1:0]        acc_addr,
    output logic [NUM_TGT-1:0]       tgt_sel,
    output logic                     acc_err,
    output logic [ADDR_W+PAGE_W-1:0] ext_addr,
    output logic                     xprog_stb,
    output logic                     xdata_stb,
    output logic                     xio_stb
);
    logic [PAGE_W-1:0] page;
    mode_t             mode;
    decode_t           dec;

    // Pick the three steering bits out of the mode word.
    always_comb begin
        mode.mpmc = pmode[MODE_MPMC_BIT];
        mode.ovly = pmode[MODE_OVLY_BIT];
        mode.drom = pmode[MODE_DROM_BIT];
    end

    msd_page_reg #(.PAGE_W(PAGE_W)) u_page (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (pg_we),
        .wdata (pg_wdata),
        .page  (page)
    );

    msd_region #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_region (
        .valid (acc_valid),
        .space (space_e'(acc_space)),
        .addr  (acc_addr),
        .page  (page),
        .mode  (mode),
        .dec   (dec)
    );

    msd_select_gen #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_sel (
        .dec       (dec),
        .addr      (acc_addr),
        .page      (page),
        .sel       (tgt_sel),
        .ext_addr  (ext_addr),
        .xprog_stb (xprog_stb),
        .xdata_stb (xdata_stb),
        .xio_stb   (xio_stb)
    );

    // Drive the error flag from the classifier.
    always_comb acc_err = dec.err;

    // R10
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_sel));
    // R10
    valid_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_err) |-> $countones(tgt_sel) == 1);
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (tgt_sel == '0 && !acc_err));
    // R3
    err_nosel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> tgt_sel == '0);
    // R7
    io_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_space == 2'b10) |-> xio_stb);
    // R8
    ext_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xprog_stb |-> ext_addr[ADDR_W+PAGE_W-1:ADDR_W] == '0);
    // R5
    rom_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_sel[T_ROM] && acc_space == 2'b00) |-> (page == '0 && !pmode[MODE_MPMC_BIT]));
endmodule

// File: tb/tb_mem_space_decoder.sv
module tb_mem_space_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pg_we = 1'b0;
    logic [3:0]  pg_wdata = '0;
    logic [15:0] pmode = '0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_space = '0;
    logic [15:0] acc_addr = '0;
    logic [6:0]  tgt_sel;
    logic        acc_err;
    logic [19:0] ext_addr;
    logic        xprog_stb, xdata_stb, xio_stb;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mem_space_decoder dut (
        .clk(clk), .rst_n(rst_n), .pg_we(pg_we), .pg_wdata(pg_wdata),
        .pmode(pmode), .acc_valid(acc_valid), .acc_space(acc_space),
        .acc_addr(acc_addr), .tgt_sel(tgt_sel), .acc_err(acc_err),
        .ext_addr(ext_addr), .xprog_stb(xprog_stb), .xdata_stb(xdata_stb),
        .xio_stb(xio_stb)
    );

    // Reference map written from the requirements.
    task automatic model(input logic [1:0] sp, input logic [15:0] a,
                         input logic [3:0] pg, input logic ov, mp, dr, vld,
                         output logic [6:0] s, output logic e,
                         output logic [19:0] x, output string tag);
        s = '0; e = 1'b0; x = '0; tag = "R10";
        if (!vld) return;
        case (sp)
            2'b00: begin
                if (a < 16'h4000) begin
                    if (ov) begin
                        tag = "R3";
                        if (a < 16'h0080) e = 1'b1;
                        else s = 7'b0000100;
                    end else begin
                        tag = "R4"; s = 7'b0010000; x = {pg, a};
                    end
                end else if (pg == 4'd0 && !mp && a >= 16'hF000) begin
                    tag = "R5"; s = 7'b0001000;
                end else begin
                    tag = "R5"; s = 7'b0010000; x = {pg, a};
                end
            end
            2'b01: begin
                if (a < 16'h0060)      begin tag = "R1"; s = 7'b0000001; end
                else if (a < 16'h0080) begin tag = "R1"; s = 7'b0000010; end
                else if (a < 16'h4000) begin tag = "R2"; s = 7'b0000100; end
                else if (dr && a >= 16'hF000 && a <= 16'hFEFF)
                                       begin tag = "R6"; s = 7'b0001000; end
                else begin tag = "R6"; s = 7'b0100000; x = {4'h0, a}; end
            end
            2'b10: begin tag = "R7"; s = 7'b1000000; x = {4'h0, a}; end
            default: begin tag = "R10"; e = 1'b1; end
        endcase
    endtask

    task automatic check(input logic [3:0] pg, input string note);
        logic [6:0] s; logic e; logic [19:0] x; string tag;
        model(acc_space, acc_addr, pg, pmode[5], pmode[6], pmode[3], acc_valid,
              s, e, x, tag);
        #1;
        compared++;
        if (tgt_sel !== s || acc_err !== e || ext_addr !== x) begin
            mismatched++;
            $display("FAIL %s%s sp=%0d a=%h pm=%h: sel=%b err=%b ext=%h expected sel=%b err=%b ext=%h",
                     tag, note, acc_space, acc_addr, pmode, tgt_sel, acc_err, ext_addr, s, e, x);
        end
        compared++;
        if ({xio_stb, xdata_stb, xprog_stb} !== s[6:4]) begin
            mismatched++;
            $display("FAIL R12 sp=%0d a=%h: stb=%b expected %b",
                     acc_space, acc_addr, {xio_stb, xdata_stb, xprog_stb}, s[6:4]);
        end
    endtask

    task automatic write_page(input logic [3:0] p);
        @(negedge clk); pg_we = 1'b1; pg_wdata = p;
        @(negedge clk); pg_we = 1'b0;
    endtask

    initial begin
        logic [3:0] pages [3];
        logic [5:0] offs [4];
        pages = '{4'd0, 4'd1, 4'd15};
        offs  = '{6'd0, 6'd31, 6'd32, 6'd63};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: after reset the page is 0.
        acc_valid = 1'b1; acc_space = 2'b00; acc_addr = 16'h8000; pmode = 16'h0040;
        check(4'd0, " reset page");
        // R10: no request, nothing selected, on every space.
        acc_valid = 1'b0;
        for (int sp = 0; sp < 4; sp++) begin
            acc_space = 2'(sp);
            check(4'd0, " idle");
        end
        acc_valid = 1'b1;
        // Sweep all spaces, modes and boundary addresses on three pages.
        foreach (pages[pi]) begin
            write_page(pages[pi]);
            for (int m = 0; m < 8; m++) begin
                for (int sp = 0; sp < 4; sp++) begin
                    for (int i = 0; i < 1024; i++) begin
                        for (int o = 0; o < 4; o++) begin
                            logic [15:0] junk;
                            // R11: junk in the ignored mode bits.
                            junk = i[0] ? 16'hFF97 : 16'h0000;
                            pmode = junk | (m[0] ? 16'h0040 : 16'h0)
                                         | (m[1] ? 16'h0020 : 16'h0)
                                         | (m[2] ? 16'h0008 : 16'h0);
                            acc_space = 2'(sp);
                            acc_addr = 16'(i * 64) + 16'(offs[o]);
                            check(pages[pi], i[0] ? "/R11" : "");
                        end
                    end
                end
            end
        end
        // R9: a write and an access in the same cycle use the old page.
        write_page(4'd3);
        @(negedge clk);
        pmode = 16'h0040; acc_space = 2'b00; acc_addr = 16'h5000;
        pg_we = 1'b1; pg_wdata = 4'd12;
        check(4'd3, " same-cycle old page");
        @(negedge clk);
        pg_we = 1'b0;
        check(4'd12, " same-cycle new page");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule